// File: doc/BRIEF.md
# CAN Controller Low-Power Mode Sequencer

This block governs the low-power modes of a CAN protocol controller. It owns a small mode-control register (halt request, sleep enable, auto-wake enable) and moves the controller through four states: normal, halt, sleep and bus resynchronisation. The protocol engine, the error counters and the register file of the controller are outside this block. The block only tells them whether they may take part on the bus, whether the error counters must hold their values, and whether a register address may be accessed at the moment.

Sleep can be entered only from halt, and only by one register write that clears the halt request and sets the sleep bit together. Sleep ends in one of two ways. Software can write 0 to the sleep bit. Or, if auto-wake is enabled, a dominant receive level can end it. After either exit, the block waits for 11 consecutive recessive bit times, counted on a per-bit tick, before it lets the controller rejoin the bus. As a result, the frame that woke the block is not received.

Top module: `can_sleep_seq`

## Requirements
- R1: After a synchronous active-low reset, the state is normal (code 0) and the halt, sleep and auto-wake bits are all 0.
- R2: In normal, a mode-control write with the halt bit (bit 1) set moves the block to halt (code 1). In halt, a write with both halt and sleep clear returns it to normal.
- R3: The sleep bit (bit 5) is set only by a write made in halt that has bit 5 set and bit 1 clear. The block then enters sleep (code 2) and the halt bit clears. Any other write that sets bit 5 leaves the sleep bit at 0 and the state unchanged.
- R4: In sleep, a mode-control write with bit 5 clear clears the sleep bit and moves the block to resync (code 3).
- R5: In sleep with the auto-wake bit (bit 7) set, a dominant receive level (rx_level = 0) clears the sleep bit and moves the block to resync.
- R6: In sleep with auto-wake clear, the receive line has no effect on the state.
- R7: In resync, the block returns to normal on the 11th consecutive bit tick that samples a recessive level. Any dominant sample resets the count to zero.
- R8: bus_enable is 1 exactly when the state is normal.
- R9: err_freeze is 1 exactly when the state is sleep.
- R10: In sleep, acc_permit is 1 only for addresses 0x00 (mode control), 0x02 (status), 0x20 (interrupt request) and 0x22 (interrupt mask). In the other states every address is permitted.
- R11: A read at address 0x00 returns bit 7 = auto-wake, bit 5 = sleep and bit 1 = halt. All other bits, including reserved bits 4 and 3, read 0, and writes to them are ignored. Reads at other addresses return 0.
- R12: mode_state encodes normal = 0, halt = 1, sleep = 2, resync = 3.
- R13: During resync, the halt and sleep bits of a write are ignored. Only auto-wake is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (write and read) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Mode-control read data, 0 at other addresses |
| rx_level | input | 1 | Sampled CAN receive level, 0 = dominant |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| mode_state | output | 2 | Current state code |
| bus_enable | output | 1 | Controller may take part on the bus |
| err_freeze | output | 1 | Error counters must hold |
| acc_permit | output | 1 | Access to reg_addr allowed |

## Verification
Directed sequences cover several cases. A sleep bit written outside halt and a sleep bit written together with a halt request show that only the combined write can enter sleep. A dominant receive level with auto-wake off and then with it on shows that wake-up by the bus is optional. A recessive run broken by a dominant bit, then an unbroken run of 11 ticks, shows that the count restarts and that the block rejoins on the 11th tick. Random writes, addresses, receive levels and tick spacing are checked every cycle against a bench model of the requirements, which also covers the access filter and the read layout in every state.

// File: rtl/can_sleep_pkg.sv
// Shared state codes and mode-control bit positions for the low-power
// sequencer. Assumes an 8-bit mode-control register.
package can_sleep_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_HALT   = 2'd1,
        MODE_SLEEP  = 2'd2,
        MODE_RESYNC = 2'd3
    } mode_e;

    localparam int REG_W     = 8;
    localparam int BIT_HALT  = 1;
    localparam int BIT_SLEEP = 5;
    localparam int BIT_AUTO  = 7;
endpackage

// File: rtl/can_sleep_ctrl.sv
// Mode-control bits and the state machine. It assumes that mcr_wr is
// already qualified by address and permit, and that resync_done pulses
// on the cycle the recessive run completes.
module can_sleep_ctrl
    import can_sleep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mcr_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             rx_level,
    input  logic             resync_done,
    output mode_e            mode_q,
    output logic             halt_q,
    output logic             sleep_q,
    output logic             auto_q
);
    mode_e mode_d;
    logic  halt_d;
    logic  sleep_d;
    logic  auto_d;
    logic  wr_halt;
    logic  wr_sleep;

    assign wr_halt  = wdata[BIT_HALT];
    assign wr_sleep = wdata[BIT_SLEEP];

    // Next state and next control bits from the current state and the write.
    always_comb begin
        mode_d  = mode_q;
        halt_d  = halt_q;
        sleep_d = sleep_q;
        auto_d  = mcr_wr ? wdata[BIT_AUTO] : auto_q;
        case (mode_q)
            MODE_NORMAL: begin
                if (mcr_wr && wr_halt) begin
                    halt_d = 1'b1;
                    mode_d = MODE_HALT;
                end
            end
            MODE_HALT: begin
                if (mcr_wr && !wr_halt) begin
                    halt_d = 1'b0;
                    if (wr_sleep) begin
                        sleep_d = 1'b1;
                        mode_d  = MODE_SLEEP;
                    end else begin
                        mode_d  = MODE_NORMAL;
                    end
                end
            end
            MODE_SLEEP: begin
                if ((auto_q && !rx_level) || (mcr_wr && !wr_sleep)) begin
                    sleep_d = 1'b0;
                    mode_d  = MODE_RESYNC;
                end
            end
            default: begin
                if (resync_done) mode_d = MODE_NORMAL;
            end
        endcase
    end

    // State and control-bit registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_NORMAL;
            halt_q  <= 1'b0;
            sleep_q <= 1'b0;
            auto_q  <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            halt_q  <= halt_d;
            sleep_q <= sleep_d;
            auto_q  <= auto_d;
        end
    end
endmodule

// File: rtl/can_sleep_recessive_cnt.sv
// Counts consecutive recessive bit ticks while active. It assumes that
// bit_tick is a single-cycle pulse. A dominant sample on any cycle, or
// leaving the active state, clears the count.
module can_sleep_recessive_cnt #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rx_level,
    input  logic bit_tick,
    output logic done
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = active && rx_level && bit_tick
                  && (cnt_q == CNT_W'(RUN_LEN - 1));

    // Run counter: restart on a dominant level, advance on a recessive tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || !rx_level) begin
            cnt_q <= '0;
        end else if (bit_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/can_sleep_access_gate.sv
// Address filter used during sleep. It assumes a fixed list of four
// addresses that stay reachable. Outside sleep every address passes.
module can_sleep_access_gate #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_MODE = 8'h00,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 8'h02,
    parameter logic [ADDR_W-1:0] ADDR_IREQ = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_IMSK = 8'h22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              in_sleep,
    output logic              permit
);
    localparam int N_OPEN = 4;
    localparam logic [ADDR_W-1:0] OPEN_LIST [N_OPEN] =
        '{ADDR_MODE, ADDR_STAT, ADDR_IREQ, ADDR_IMSK};

    logic [N_OPEN-1:0] hit;

    for (genvar i = 0; i < N_OPEN; i++) begin : g_cmp
        assign hit[i] = (addr == OPEN_LIST[i]);
    end

    assign permit = !in_sleep || (|hit);
endmodule

// File: rtl/can_sleep_seq.sv
// Top level of the low-power sequencer. It combines the control FSM, the
// recessive-run counter and the sleep access filter. It assumes that the
// register file outside this block honours acc_permit.
module can_sleep_seq
    import can_sleep_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              RUN_LEN   = 11,
    parameter logic [ADDR_W-1:0] ADDR_MODE = 8'h00,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 8'h02,
    parameter logic [ADDR_W-1:0] ADDR_IREQ = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_IMSK = 8'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rx_level,
    input  logic              bit_tick,
    output logic [1:0]        mode_state,
    output logic              bus_enable,
    output logic              err_freeze,
    output logic              acc_permit
);
    mode_e mode_q;
    logic  halt_bit;
    logic  sleep_bit;
    logic  auto_bit;
    logic  resync_done;
    logic  mcr_sel;
    logic  mcr_wr;

    assign mcr_sel = (reg_addr == ADDR_MODE);
    assign mcr_wr  = reg_wr && mcr_sel && acc_permit;

    can_sleep_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mcr_wr      (mcr_wr),
        .wdata       (reg_wdata),
        .rx_level    (rx_level),
        .resync_done (resync_done),
        .mode_q      (mode_q),
        .halt_q      (halt_bit),
        .sleep_q     (sleep_bit),
        .auto_q      (auto_bit)
    );

    can_sleep_recessive_cnt #(.RUN_LEN(RUN_LEN)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (mode_q == MODE_RESYNC),
        .rx_level (rx_level),
        .bit_tick (bit_tick),
        .done     (resync_done)
    );

    can_sleep_access_gate #(
        .ADDR_W    (ADDR_W),
        .ADDR_MODE (ADDR_MODE),
        .ADDR_STAT (ADDR_STAT),
        .ADDR_IREQ (ADDR_IREQ),
        .ADDR_IMSK (ADDR_IMSK)
    ) u_gate (
        .addr     (reg_addr),
        .in_sleep (mode_q == MODE_SLEEP),
        .permit   (acc_permit)
    );

    // Read mux: live control bits at the mode-control address, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        if (mcr_sel) begin
            reg_rdata[BIT_AUTO]  = auto_bit;
            reg_rdata[BIT_SLEEP] = sleep_bit;
            reg_rdata[BIT_HALT]  = halt_bit;
        end
    end

    assign mode_state = mode_q;
    assign bus_enable = (mode_q == MODE_NORMAL);
    assign err_freeze = (mode_q == MODE_SLEEP);
endmodule

// File: rtl/can_sleep_seq_checker.sv
// Temporal checks for can_sleep_seq. It is attached by bind and observes
// the ports and the auto-wake bit.
module can_sleep_seq_checker #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_MODE = 8'h00,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 8'h02,
    parameter logic [ADDR_W-1:0] ADDR_IREQ = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_IMSK = 8'h22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              rx_level,
    input logic              bit_tick,
    input logic [1:0]        mode_state,
    input logic              acc_permit,
    input logic              auto_q
);
    logic open_addr;
    assign open_addr = (reg_addr == ADDR_MODE) || (reg_addr == ADDR_STAT)
                    || (reg_addr == ADDR_IREQ) || (reg_addr == ADDR_IMSK);

    a_r3_sleep_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == 2'd2) |-> ($past(mode_state) == 2'd1 || $past(mode_state) == 2'd2));

    a_r5_auto_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == 2'd2 && auto_q && !rx_level) |=> (mode_state == 2'd3));

    a_r6_bus_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == 2'd2 && !auto_q && !(reg_wr && reg_addr == ADDR_MODE))
        |=> (mode_state == 2'd2));

    a_r7_rejoin_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == 2'd0 && $past(mode_state) == 2'd3)
        |-> ($past(bit_tick) && $past(rx_level)));

    a_r10_sleep_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == 2'd2 && !open_addr) |-> !acc_permit);
endmodule

bind can_sleep_seq can_sleep_seq_checker #(
    .ADDR_W    (ADDR_W),
    .ADDR_MODE (ADDR_MODE),
    .ADDR_STAT (ADDR_STAT),
    .ADDR_IREQ (ADDR_IREQ),
    .ADDR_IMSK (ADDR_IMSK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .rx_level   (rx_level),
    .bit_tick   (bit_tick),
    .mode_state (mode_state),
    .acc_permit (acc_permit),
    .auto_q     (auto_bit)
);

// File: tb/can_sleep_seq_bench.sv
// Self-checking bench: directed corner cases followed by seeded random
// stimulus, compared every cycle against a bench model of the requirements.
module can_sleep_seq_bench;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_level = 1'b1;
    logic       bit_tick = 1'b0;
    logic [1:0] mode_state;
    logic       bus_enable;
    logic       err_freeze;
    logic       acc_permit;

    int checks = 0;
    int errors = 0;

    // Bench model state.
    int m_state = 0;
    bit m_halt = 0, m_sleep = 0, m_auto = 0;
    int m_cnt = 0;

    always #(CLK_NS/2) clk = ~clk;

    can_sleep_seq u_can_sleep_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
        .bit_tick(bit_tick), .mode_state(mode_state), .bus_enable(bus_enable),
        .err_freeze(err_freeze), .acc_permit(acc_permit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit open_addr(input logic [7:0] a);
        return a == 8'h00 || a == 8'h02 || a == 8'h20 || a == 8'h22;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [7:0] a);
        if (a != 8'h00) return 8'h00;
        return {m_auto, 1'b0, m_sleep, 3'b000, m_halt, 1'b0};
    endfunction

    task automatic check_outputs();
        chk(mode_state == m_state[1:0], "R12 mode_state", mode_state, m_state);
        chk(bus_enable == (m_state == 0), "R8 bus_enable", bus_enable, m_state == 0);
        chk(err_freeze == (m_state == 2), "R9 err_freeze", err_freeze, m_state == 2);
        chk(acc_permit == (m_state != 2 || open_addr(reg_addr)), "R10 acc_permit",
            acc_permit, m_state != 2 || open_addr(reg_addr));
        chk(reg_rdata == exp_rdata(reg_addr), "R11 reg_rdata", reg_rdata, exp_rdata(reg_addr));
    endtask

    // Model update at a clock edge, following the requirements.
    task automatic model_edge(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                              input bit rx, input bit tk);
        bit w;
        w = wr && (a == 8'h00);
        case (m_state)
            0: if (w && wd[1]) begin m_halt = 1; m_state = 1; end            // R2
            1: if (w && !wd[1]) begin                                       // R2 R3
                   m_halt = 0;
                   if (wd[5]) begin m_sleep = 1; m_state = 2; end
                   else m_state = 0;
               end
            2: if ((m_auto && !rx) || (w && !wd[5])) begin                  // R4 R5 R6
                   m_sleep = 0; m_state = 3; m_cnt = 0;
               end
            default: begin                                                  // R7 R13
                if (!rx) m_cnt = 0;
                else if (tk) begin
                    if (m_cnt == 10) begin m_state = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            end
        endcase
        if (w) m_auto = wd[7];
    endtask

    task automatic step(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                        input bit rx, input bit tk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; rx_level = rx; bit_tick = tk;
        #1;
        check_outputs();
        @(posedge clk);
        model_edge(wr, a, wd, rx, tk);
        @(negedge clk);
    endtask

    task automatic idle(input bit rx, input bit tk);
        step(1'b0, 8'h00, 8'h00, rx, tk);
    endtask

    task automatic expect_mode(input int m, input string tag);
        #1;
        chk(mode_state == m[1:0], tag, mode_state, m);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_NS * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        #1;
        chk(mode_state == 2'd0 && reg_rdata == 8'h00 && bus_enable && !err_freeze,
            "R1 reset state", {mode_state, reg_rdata}, 0);
        // R3: sleep bit written in normal is ignored.
        step(1, 8'h00, 8'h20, 1, 0);
        expect_mode(0, "R3 sleep outside halt ignored");
        chk(reg_rdata[5] == 1'b0, "R3 sleep bit stays 0", reg_rdata, 0);
        // R2: enter halt.
        step(1, 8'h00, 8'h02, 1, 0);
        expect_mode(1, "R2 halt entry");
        // R11: reserved bits 4 and 3 ignored.
        step(1, 8'h00, 8'h1A, 1, 0);
        chk(reg_rdata == 8'h02, "R11 reserved bits read 0", reg_rdata, 8'h02);
        // R3: sleep together with the halt request is not a legal entry.
        step(1, 8'h00, 8'h22, 1, 0);
        expect_mode(1, "R3 sleep with halt kept is ignored");
        // R3: combined write enters sleep.
        step(1, 8'h00, 8'h20, 1, 0);
        expect_mode(2, "R3 combined write enters sleep");
        // R6: dominant bus without auto-wake has no effect.
        repeat (5) idle(0, 1);
        expect_mode(2, "R6 bus ignored in sleep");
        step(0, 8'h10, 8'h00, 1, 0);
        step(0, 8'h20, 8'h00, 1, 0);
        // R4: clearing the sleep bit leaves sleep.
        step(1, 8'h00, 8'h00, 1, 0);
        expect_mode(3, "R4 software exit to resync");
        // R13: halt write ignored during resync.
        step(1, 8'h00, 8'h02, 1, 1);
        expect_mode(3, "R13 halt ignored in resync");
        // R7: a broken run restarts the count.
        repeat (6) idle(1, 1);
        idle(0, 0);
        repeat (10) idle(1, 1);
        expect_mode(3, "R7 ten ticks not enough");
        idle(1, 0);
        idle(1, 1);
        expect_mode(0, "R7 rejoin on eleventh tick");
        // R5: auto-wake by a dominant level.
        step(1, 8'h00, 8'h82, 1, 0);
        step(1, 8'h00, 8'hA0, 1, 0);
        expect_mode(2, "R3 sleep with auto-wake");
        idle(0, 0);
        expect_mode(3, "R5 auto wake to resync");
        chk(reg_rdata == 8'h80, "R5 sleep bit cleared", reg_rdata, 8'h80);
        // Random phase.
        for (int i = 0; i < 6000; i++) begin
            int unsigned r;
            bit wr, rx, tk;
            logic [7:0] a, wd;
            r  = $urandom % 100;
            wr = (r < 15);
            a  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            case ($urandom % 6)
                0: wd = 8'h02;
                1: wd = 8'h20;
                2: wd = 8'hA0;
                3: wd = 8'h00;
                4: wd = 8'h80;
                default: wd = 8'($urandom);
            endcase
            rx = ($urandom % 100) >= 3;
            tk = ($urandom % 3) == 0;
            step(wr, a, wd, rx, tk);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule